// File: doc/BRIEF.md
# Lockable Flash Control Register

This block holds the control word of a flash controller and enforces who may change which bit and when. Software reaches it through a simple word-addressed register bus with write enable, read enable, byte strobes and write data. Three word addresses are decoded. Word 0 is the control word. Word 1 takes the keys that open the main lock. Word 2 takes the keys that open the option lock. Reads are combinational and return data in the same cycle as the read enable. The bus has no back-pressure: every access completes in its own cycle, so there is no valid/ready pair, and all control and status pins are plain levels.

After reset both locks are closed. Writing the right pair of key words in order opens a lock. Any mistake closes that lock until the next reset. While the main lock is closed, only the lock bits accept writes. Option-related bits also need the option lock to be open. The two protection bits can only be set, and only reset clears them. The option-load launch bit clears itself when the load-done input pulses. A configuration-busy input blocks every write to the control word. The interrupt output passes the read-error flag when its enable bit is set.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset the control word reads 0xC000_0000, with bit 31 (main lock) and bit 30 (option lock) set and all other bits clear. Words 1 and 2 always read zero.
- R2: A write of 0xA5A5_1234 followed directly by a write of 0x5A5A_CDEF to word 1 clears bit 31. Writing 1 to bit 31 with byte strobe 3 sets it again, and a later correct pair clears it once more. Writing 0 to bit 31 has no effect.
- R3: A wrong word, the two words in the wrong order, or any key write while bit 31 is already clear leaves bit 31 set. It then stays set through any later correct key pair, until reset.
- R4: A write of 0x1357_9BDF followed by 0x2468_ACE0 to word 2 clears bit 30, but only while bit 31 is clear. An option key write while bit 31 is set counts as a failure. Failures follow the same lockout rule as R3. Writing 1 to bit 30 sets it again.
- R5: While bit 31 is set, writes to bits 29 to 0 of the control word are ignored.
- R6: Bits 26, 17, 16, 15, 13, 2, 1 and 0 are read/write when the main lock is open. Each bit changes only if the byte strobe of its byte (bus_be[i] covers bits 8i+7 to 8i) is set. Bit 17 is also ignored while bit 30 is set.
- R7: Bits 28 and 29 can be set by software and are cleared only by reset. Writing 0 to them has no effect. sec_prot1_active equals bit 28 AND (sec_size1 nonzero). sec_prot2_active equals bit 29 AND (sec_size2 nonzero).
- R8: Writing 1 to bit 27 sets it only while both locks are open. Writing 0 does not clear it. It clears in the cycle after opt_load_done is high.
- R9: While cfg_busy is high, writes to the control word change no bit, including the lock bits.
- R10: irq is high exactly when bit 26 is set and rd_err_flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Word address (0 control, 1 main key, 2 option key) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes for control-word writes |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable; bus_rdata is zero when low |
| bus_rdata | output | 32 | Read data, combinational |
| cfg_busy | input | 1 | Configuration busy; blocks control-word writes |
| opt_load_done | input | 1 | One-cycle pulse when an option-byte load ends |
| rd_err_flag | input | 1 | Read-error flag from the flash array |
| sec_size1 | input | SECW | Securable area size, bank 1 |
| sec_size2 | input | SECW | Securable area size, bank 2 |
| ctrl_q | output | 32 | Current control word |
| sec_prot1_active | output | 1 | Bank 1 protection in force |
| sec_prot2_active | output | 1 | Bank 2 protection in force |
| irq | output | 1 | Read-error interrupt request |

## Verification
The key sequencers are driven with four kinds of failure: a bad first word, a bad second word, a reversed pair, and a repeat while open. Each failure is followed by a correct pair, which shows that the lockout lasts and that it differs from a plain relock. Byte-strobe handling is swept over all sixteen strobe values, and each write flips every writable bit. A single missing or extra byte lane therefore shows in the readback. The option unlock is tried both before and after the main unlock, which separates the ordering rule from the key values. Writes under busy, writes of zero to sticky and self-clearing bits, and the load-done pulse show which source may clear each bit.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned B_LOCK    = 31;
  localparam int unsigned B_OLOCK   = 30;
  localparam int unsigned B_PROT1   = 28;
  localparam int unsigned B_LAUNCH  = 27;
  localparam int unsigned B_RDEIE   = 26;
  localparam int unsigned B_OSTART  = 17;

  // plain read/write fields: 26, 17, 16, 15, 13, 2, 1, 0
  localparam logic [DW-1:0] RW_MASK  = 32'h0403_A007;
  localparam logic [DW-1:0] OPT_MASK = 32'h0002_0000;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_KEY  = 1;
  localparam int unsigned A_OKEY = 2;

  typedef enum logic [1:0] {
    KS_SHUT = 2'd0,
    KS_HALF = 2'd1,
    KS_OPEN = 2'd2,
    KS_DEAD = 2'd3
  } key_state_e;
endpackage

// File: rtl/flash_key_seq.sv
module flash_key_seq
  import flash_ctl_pkg::*;
#(
  parameter logic [DW-1:0] K_FIRST  = 32'h0,
  parameter logic [DW-1:0] K_SECOND = 32'h1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic [DW-1:0] key_data,
  input  logic          allow,
  input  logic          relock,
  output logic          locked
);
  key_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= KS_SHUT;
    end else begin
      case (st_q)
        KS_SHUT: if (key_we) st_q <= (allow && key_data == K_FIRST) ? KS_HALF : KS_DEAD;
        KS_HALF: if (key_we) st_q <= (allow && key_data == K_SECOND) ? KS_OPEN : KS_DEAD;
        KS_OPEN: begin
          if (key_we)      st_q <= KS_DEAD;
          else if (relock) st_q <= KS_SHUT;
        end
        KS_DEAD: st_q <= KS_DEAD;
        default: st_q <= KS_DEAD;
      endcase
    end
  end

  assign locked = (st_q != KS_OPEN);
endmodule

// File: rtl/flash_ctl_fields.sv
module flash_ctl_fields
  import flash_ctl_pkg::*;
#(
  parameter int unsigned NBYTE = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic [NBYTE-1:0] be,
  input  logic             main_locked,
  input  logic             opt_locked,
  input  logic             load_done,
  output logic [DW-3:0]    fields,
  output logic             relock_main,
  output logic             relock_opt
);
  localparam int unsigned NPROT = 2;

  logic [DW-1:0]    lane_mask;
  logic [DW-1:0]    wmask;
  logic [DW-1:0]    open_mask;
  logic [DW-1:0]    rw_q;
  logic [NPROT-1:0] prot_q;
  logic             launch_q;
  logic             launch_req;

  genvar gi;
  generate
    for (gi = 0; gi < NBYTE; gi++) begin : g_lane
      assign lane_mask[8*gi +: 8] = {8{be[gi]}};
    end
  endgenerate

  assign wmask     = wr ? lane_mask : '0;
  assign open_mask = main_locked ? '0 : (RW_MASK & ~(opt_locked ? OPT_MASK : '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rw_q <= '0;
    else        rw_q <= (rw_q & ~(wmask & open_mask)) | (wdata & wmask & open_mask);
  end

  generate
    for (gi = 0; gi < NPROT; gi++) begin : g_prot
      localparam int unsigned POS = B_PROT1 + gi;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_q[gi] <= 1'b0;
        else if (wmask[POS] && wdata[POS] && !main_locked) prot_q[gi] <= 1'b1;
      end
    end
  endgenerate

  assign launch_req = wmask[B_LAUNCH] & wdata[B_LAUNCH] & ~main_locked & ~opt_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        launch_q <= 1'b0;
    else if (launch_q) launch_q <= ~load_done;
    else               launch_q <= launch_req;
  end

  always_comb begin
    fields = rw_q[DW-3:0];
    fields[B_PROT1 +: NPROT] = prot_q;
    fields[B_LAUNCH] = launch_q;
  end

  assign relock_main = wmask[B_LOCK] & wdata[B_LOCK];
  assign relock_opt  = wmask[B_OLOCK] & wdata[B_OLOCK];
endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import flash_ctl_pkg::*;
#(
  parameter int unsigned     AW     = 4,
  parameter int unsigned     SECW   = 8,
  parameter logic [DW-1:0]   KEY_A  = 32'hA5A5_1234,
  parameter logic [DW-1:0]   KEY_B  = 32'h5A5A_CDEF,
  parameter logic [DW-1:0]   OKEY_A = 32'h1357_9BDF,
  parameter logic [DW-1:0]   OKEY_B = 32'h2468_ACE0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [DW/8-1:0] bus_be,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [DW-1:0]   bus_rdata,
  input  logic            cfg_busy,
  input  logic            opt_load_done,
  input  logic            rd_err_flag,
  input  logic [SECW-1:0] sec_size1,
  input  logic [SECW-1:0] sec_size2,
  output logic [DW-1:0]   ctrl_q,
  output logic            sec_prot1_active,
  output logic            sec_prot2_active,
  output logic            irq
);
  logic          sel_ctrl, sel_key, sel_okey;
  logic          main_locked, opt_locked;
  logic          relock_main, relock_opt;
  logic [DW-3:0] fields;

  assign sel_ctrl = (bus_addr == AW'(A_CTRL));
  assign sel_key  = (bus_addr == AW'(A_KEY));
  assign sel_okey = (bus_addr == AW'(A_OKEY));

  flash_key_seq #(.K_FIRST(KEY_A), .K_SECOND(KEY_B)) u_main_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (bus_we && sel_key),
    .key_data (bus_wdata),
    .allow    (1'b1),
    .relock   (relock_main),
    .locked   (main_locked)
  );

  flash_key_seq #(.K_FIRST(OKEY_A), .K_SECOND(OKEY_B)) u_opt_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (bus_we && sel_okey),
    .key_data (bus_wdata),
    .allow    (!main_locked),
    .relock   (relock_opt),
    .locked   (opt_locked)
  );

  flash_ctl_fields u_fields (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (bus_we && sel_ctrl && !cfg_busy),
    .wdata       (bus_wdata),
    .be          (bus_be),
    .main_locked (main_locked),
    .opt_locked  (opt_locked),
    .load_done   (opt_load_done),
    .fields      (fields),
    .relock_main (relock_main),
    .relock_opt  (relock_opt)
  );

  assign ctrl_q           = {main_locked, opt_locked, fields};
  assign bus_rdata        = (bus_re && sel_ctrl) ? ctrl_q : '0;
  assign sec_prot1_active = ctrl_q[B_PROT1]     && (sec_size1 != '0);
  assign sec_prot2_active = ctrl_q[B_PROT1 + 1] && (sec_size2 != '0);
  assign irq              = ctrl_q[B_RDEIE] && rd_err_flag;
endmodule

// File: rtl/flash_ctl_reg_chk.sv
module flash_ctl_reg_chk
  import flash_ctl_pkg::*;
#(
  parameter int unsigned   AW     = 4,
  parameter logic [DW-1:0] KEY_B  = 32'h5A5A_CDEF,
  parameter logic [DW-1:0] OKEY_B = 32'h2468_ACE0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic          cfg_busy,
  input logic          opt_load_done,
  input logic [DW-1:0] ctrl_q
);
  // R2
  main_unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[B_LOCK]) |-> $past(bus_we && bus_addr == AW'(A_KEY) && bus_wdata == KEY_B));

  // R4
  opt_unlock_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[B_OLOCK]) |-> $past(!ctrl_q[B_LOCK] && bus_we && bus_addr == AW'(A_OKEY)
                                     && bus_wdata == OKEY_B));

  // R7
  prot1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ctrl_q[B_PROT1]));

  // R7
  prot2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ctrl_q[B_PROT1 + 1]));

  // R8
  launch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_LAUNCH] && opt_load_done) |=> !ctrl_q[B_LAUNCH]);

  // R8
  launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[B_LAUNCH]) |-> $past(!ctrl_q[B_OLOCK] && !ctrl_q[B_LOCK]));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_busy && bus_we && bus_addr == AW'(A_CTRL) && !opt_load_done) |=> $stable(ctrl_q));

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_LOCK] && !opt_load_done) |=> ctrl_q[29:0] == $past(ctrl_q[29:0]));
endmodule

bind flash_ctl_reg flash_ctl_reg_chk #(.AW(AW), .KEY_B(KEY_B), .OKEY_B(OKEY_B)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_we        (bus_we),
  .cfg_busy      (cfg_busy),
  .opt_load_done (opt_load_done),
  .ctrl_q        (ctrl_q)
);

// File: tb/flash_ctl_reg_test.sv
module flash_ctl_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KA  = 32'hA5A5_1234;
  localparam logic [31:0] KB  = 32'h5A5A_CDEF;
  localparam logic [31:0] OKA = 32'h1357_9BDF;
  localparam logic [31:0] OKB = 32'h2468_ACE0;
  localparam logic [31:0] RWM = 32'h0403_A007;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        cfg_busy = 1'b0;
  logic        opt_load_done = 1'b0;
  logic        rd_err_flag = 1'b0;
  logic [7:0]  sec_size1 = '0;
  logic [7:0]  sec_size2 = '0;
  logic [31:0] ctrl_q;
  logic        sec_prot1_active, sec_prot2_active, irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_ctl_reg uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .cfg_busy(cfg_busy), .opt_load_done(opt_load_done), .rd_err_flag(rd_err_flag),
    .sec_size1(sec_size1), .sec_size2(sec_size2), .ctrl_q(ctrl_q),
    .sec_prot1_active(sec_prot1_active), .sec_prot2_active(sec_prot2_active), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(4'd0, d);
    check(tag, d, exp);
  endtask

  task automatic unlock_main();
    wr(4'd1, KA, 4'hF);
    wr(4'd1, KB, 4'hF);
  endtask

  task automatic unlock_opt();
    wr(4'd2, OKA, 4'hF);
    wr(4'd2, OKB, 4'hF);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    do_reset();
    // R1 reset value and key words read zero
    rd_check("R1 reset", 32'hC000_0000);
    rd(4'd1, d); check("R1 key reads 0", d, 32'h0);
    rd(4'd2, d); check("R1 okey reads 0", d, 32'h0);

    // R5 writes ignored while locked
    wr(4'd0, 32'h3FFF_FFFF, 4'hF);
    rd_check("R5 locked write ignored", 32'hC000_0000);

    // R4 option keys while main locked -> failure
    unlock_opt();
    unlock_main();
    rd_check("R2 main unlock", 32'h4000_0000);
    unlock_opt();
    rd_check("R4 option lockout after early keys", 32'h4000_0000);

    // R2 relock by software and reopen; writing 0 to lock no effect
    wr(4'd0, 32'h0000_0000, 4'hF);
    rd_check("R2 write zero no effect", 32'h4000_0000);
    wr(4'd0, 32'h8000_0000, 4'h8);
    rd_check("R2 software relock", 32'hC000_0000);
    unlock_main();
    rd_check("R2 reopen after relock", 32'h4000_0000);

    // R3 key write while open
    wr(4'd1, KA, 4'hF);
    rd_check("R3 key while open locks", 32'hC000_0000);
    unlock_main();
    rd_check("R3 lockout persists (open)", 32'hC000_0000);

    // R3 bad first word
    do_reset();
    wr(4'd1, 32'h1234_5678, 4'hF);
    unlock_main();
    rd_check("R3 bad first word", 32'hC000_0000);
    // R3 bad second word
    do_reset();
    wr(4'd1, KA, 4'hF);
    wr(4'd1, KA, 4'hF);
    unlock_main();
    rd_check("R3 bad second word", 32'hC000_0000);
    // R3 reversed order
    do_reset();
    wr(4'd1, KB, 4'hF);
    wr(4'd1, KA, 4'hF);
    unlock_main();
    rd_check("R3 reversed order", 32'hC000_0000);

    // R4 option failure lockout with main open
    do_reset();
    unlock_main();
    wr(4'd2, OKB, 4'hF);
    unlock_opt();
    rd_check("R4 bad option order", 32'h4000_0000);

    // R6 bit 17 needs option lock open
    do_reset();
    unlock_main();
    wr(4'd0, 32'h0002_0000, 4'hF);
    rd_check("R6 opt-start blocked by option lock", 32'h4000_0000);
    // R8 launch blocked while option lock set
    wr(4'd0, 32'h0800_0000, 4'hF);
    rd_check("R8 launch blocked by option lock", 32'h4000_0000);

    unlock_opt();
    rd_check("R4 option unlock", 32'h0000_0000);

    // R6 byte strobe sweep
    model = 32'h0;
    for (int be = 0; be < 16; be++) begin
      logic [31:0] bm, dat;
      dat = (~model) & RWM;
      bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
      wr(4'd0, dat, be[3:0]);
      model = (model & ~bm) | (dat & bm);
      rd_check($sformatf("R6 strobe sweep be=%0d", be), model);
    end
    wr(4'd0, 32'h0, 4'hF);
    model = 32'h0;

    // R10 interrupt gating
    rd_err_flag = 1'b1;
    #1 check("R10 irq masked", {31'h0, irq}, 32'h0);
    wr(4'd0, 32'h0400_0000, 4'h8);
    #1 check("R10 irq enabled", {31'h0, irq}, 32'h1);
    rd_err_flag = 1'b0;
    #1 check("R10 irq flag low", {31'h0, irq}, 32'h0);
    wr(4'd0, 32'h0, 4'hF);

    // R7 sticky protection and size gating
    wr(4'd0, 32'h1000_0000, 4'h8);
    rd_check("R7 prot1 set", 32'h1000_0000);
    #1 check("R7 prot1 inactive size 0", {31'h0, sec_prot1_active}, 32'h0);
    sec_size1 = 8'h04;
    #1 check("R7 prot1 active", {31'h0, sec_prot1_active}, 32'h1);
    wr(4'd0, 32'h2000_0000, 4'h8);
    wr(4'd0, 32'h0000_0000, 4'hF);
    rd_check("R7 prot bits sticky", 32'h3000_0000);
    sec_size2 = 8'h01;
    #1 check("R7 prot2 active", {31'h0, sec_prot2_active}, 32'h1);

    // R8 launch self-clearing
    wr(4'd0, 32'h0800_0000, 4'h8);
    rd_check("R8 launch set", 32'h3800_0000);
    wr(4'd0, 32'h0000_0000, 4'hF);
    rd_check("R8 launch not cleared by sw", 32'h3800_0000);
    @(negedge clk); opt_load_done = 1'b1;
    @(negedge clk); opt_load_done = 1'b0;
    rd_check("R8 launch cleared on done", 32'h3000_0000);

    // R9 busy blocks all control writes
    cfg_busy = 1'b1;
    wr(4'd0, 32'hFFFF_FFFF, 4'hF);
    rd_check("R9 busy blocks write", 32'h3000_0000);
    cfg_busy = 1'b0;
    wr(4'd0, 32'h0000_0001, 4'h1);
    rd_check("R9 write after busy", 32'h3000_0001);

    // R7 reset clears protection
    do_reset();
    rd_check("R7 reset clears prot", 32'hC000_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule